// File: doc/BRIEF.md
# Turbo Frequency Step Governor

This block picks the shared operating frequency of a multi-core chip that may run above its software-chosen baseline. A free-running counter divides the clock into control intervals. On the last cycle of each interval the block samples three independent limit checks: a temperature reading, a package power estimate and a current-draw flag. If any one of them is over its limit, the frequency code moves one 100 MHz step down. If none is over and the code is below the allowed maximum, it moves one step up.

The allowed maximum depends on how many cores are active. Fewer active cores give a higher ceiling. The software baseline is the lowest value the governor will ever leave the code at. One code, in 100 MHz units, is driven to every active core. When turbo is disabled, or when no core is active, the code is held at the baseline.

Top module: `turbo_step_gov`

## Requirements
- R1: `freq_code` changes only on the clock edge that ends a control interval of `TICK_CYCLES` cycles (the first interval ends `TICK_CYCLES` edges after reset is released). Between those edges it holds its value, except as stated in R7.
- R2: At the end of an interval, if `temp_c > 76`, or `power_w > 115`, or `current_over` is 1, the code drops by exactly 1. A reading equal to a limit does not count as over.
- R3: At the end of an interval with no limit over and the code below the ceiling, the code rises by exactly 1.
- R4: The ceiling is set by `active_cores`: 1 core gives 32, 2 cores give 31, 3 cores give 30, 4 cores give 29, and 5 or more give 28. At the ceiling with no limit over, the code holds.
- R5: After any interval end the code is never below the effective baseline. The effective baseline is `base_code` clamped to the range 12..24. A baseline raised above the code lifts the code to the baseline at the next interval end.
- R6: If the ceiling falls below the code, the code equals the new ceiling after the next interval end. This holds even when a limit is over in that same interval.
- R7: While `turbo_en` is 0 or `active_cores` is 0, the code equals the effective baseline from the next clock edge, whether or not an interval ends.
- R8: Reset (`rst_n` low, asynchronous) sets `freq_code` to 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| turbo_en | input | 1 | 1 allows operation above the baseline |
| base_code | input | FW (6) | Software baseline code, 100 MHz units |
| active_cores | input | CW (4) | Number of active cores |
| temp_c | input | TW (8) | Temperature reading in degrees C |
| power_w | input | PW (8) | Package power estimate in watts |
| current_over | input | 1 | Current-draw limit flag |
| freq_code | output | FW (6) | Shared frequency code, 100 MHz units |

## Verification
The main collision is a limit step-down and a ceiling clamp landing on the same interval end. The bench provokes it by raising the core count and the temperature together while the code sits at the one-core ceiling of 32. A single step down would give 31, but the code must land on the new ceiling of 28. A second collision puts a sustained over-limit condition against the baseline floor, and then against a baseline changed to values outside 12..24. A behavioural model of the governor is compared with `freq_code` on every clock, and this is backed by directed checks at each of these points.

// File: rtl/turbo_step_gov.sv
module turbo_step_gov #(
  parameter int FW          = 6,
  parameter int CW          = 4,
  parameter int TW          = 8,
  parameter int PW          = 8,
  parameter int TICK_CYCLES = 1000,
  parameter int TEMP_LIMIT  = 76,
  parameter int POWER_LIMIT = 115,
  parameter int BASE_MIN    = 12,
  parameter int BASE_MAX    = 24,
  parameter int CEIL_TOP    = 32,
  parameter int CEIL_FLOOR  = 28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          turbo_en,
  input  logic [FW-1:0] base_code,
  input  logic [CW-1:0] active_cores,
  input  logic [TW-1:0] temp_c,
  input  logic [PW-1:0] power_w,
  input  logic          current_over,
  output logic [FW-1:0] freq_code
);
  localparam int TCW   = $clog2(TICK_CYCLES + 1);
  localparam int STEPS = CEIL_TOP - CEIL_FLOOR;

  logic [TCW-1:0] cnt;
  logic           tick, idle, over;
  logic [FW-1:0]  base_c, ceil_c, nxt;

  assign tick = (cnt == TCW'(TICK_CYCLES - 1));
  assign idle = !turbo_en || (active_cores == '0);
  assign over = (temp_c > TW'(TEMP_LIMIT)) || (power_w > PW'(POWER_LIMIT)) || current_over;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   cnt <= '0;
    else if (tick) cnt <= '0;
    else          cnt <= cnt + 1'b1;

  always_comb begin
    if (base_code < FW'(BASE_MIN))      base_c = FW'(BASE_MIN);
    else if (base_code > FW'(BASE_MAX)) base_c = FW'(BASE_MAX);
    else                                base_c = base_code;
  end

  always_comb begin
    if (active_cores == '0 || int'(active_cores) > STEPS) ceil_c = FW'(CEIL_FLOOR);
    else ceil_c = FW'(CEIL_TOP + 1 - int'(active_cores));
  end

  always_comb begin
    nxt = freq_code;
    if (over) begin
      if (freq_code != '0) nxt = freq_code - 1'b1;
    end else if (freq_code < ceil_c) begin
      nxt = freq_code + 1'b1;
    end
    if (nxt > ceil_c) nxt = ceil_c;
    if (nxt < base_c) nxt = base_c;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    freq_code <= FW'(BASE_MIN);
    else if (idle) freq_code <= base_c;
    else if (tick) freq_code <= nxt;

  a_r1_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !idle) |=> $stable(freq_code));

  a_r2_single_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !idle && over && freq_code > base_c && freq_code <= ceil_c)
      |=> (freq_code + 1'b1) == $past(freq_code));

  a_r4_within_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !idle) |=> freq_code <= $past(ceil_c));

  a_r5_above_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !idle) |=> freq_code >= $past(base_c));

  a_r7_idle_baseline: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> freq_code == $past(base_c));
endmodule

// File: tb/turbo_step_gov_tb.sv
module turbo_step_gov_tb_top;
  localparam int PERIOD = 10;
  localparam int TICK   = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       turbo_en = 1'b0;
  logic [5:0] base_code = 6'd20;
  logic [3:0] active_cores = 4'd8;
  logic [7:0] temp_c = 8'd50;
  logic [7:0] power_w = 8'd80;
  logic       current_over = 1'b0;
  logic [5:0] freq_code;

  int checks = 0, fails = 0;
  int m_f = 12, m_cnt = 0;
  string cur_req = "R8";

  always #(PERIOD/2) clk = ~clk;

  turbo_step_gov #(.TICK_CYCLES(TICK)) dut_i (
    .clk(clk), .rst_n(rst_n), .turbo_en(turbo_en), .base_code(base_code),
    .active_cores(active_cores), .temp_c(temp_c), .power_w(power_w),
    .current_over(current_over), .freq_code(freq_code));

  function automatic int eff_base(int b);
    if (b < 12) return 12;
    if (b > 24) return 24;
    return b;
  endfunction

  function automatic int ceiling(int n);
    if (n >= 5 || n == 0) return 28;
    return 33 - n;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_f = 12; m_cnt = 0;
    end else begin
      bit t, lim;
      int b, c;
      t   = (m_cnt == TICK - 1);
      b   = eff_base(base_code);
      c   = ceiling(active_cores);
      lim = (temp_c > 76) || (power_w > 115) || current_over;
      if (!turbo_en || active_cores == 0) m_f = b;
      else if (t) begin
        if (lim) m_f = m_f - 1;
        else if (m_f < c) m_f = m_f + 1;
        if (m_f > c) m_f = c;
        if (m_f < b) m_f = b;
      end
      m_cnt = t ? 0 : m_cnt + 1;
    end
  end

  always @(negedge clk) begin
    checks++;
    if (int'(freq_code) != m_f) begin
      fails++;
      $display("FAIL %s cycle compare: actual %0d expected %0d", cur_req, freq_code, m_f);
    end
  end

  task automatic chk(input string req, input int exp);
    checks++;
    if (int'(freq_code) != exp) begin
      fails++;
      $display("FAIL %s directed: actual %0d expected %0d", req, freq_code, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n * TICK) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int hold;
    repeat (3) @(negedge clk);
    chk("R8", 12);
    rst_n = 1'b1; turbo_en = 1'b1;
    cur_req = "R5"; ticks(1); chk("R5", 20);
    cur_req = "R3"; ticks(9); chk("R4", 28);
    cur_req = "R4"; active_cores = 4'd1; ticks(6); chk("R4", 32);
    cur_req = "R1"; active_cores = 4'd3; hold = int'(freq_code);
    repeat (TICK - 1) @(negedge clk); chk("R1", hold);
    @(negedge clk); chk("R6", 30);
    cur_req = "R6"; active_cores = 4'd5; ticks(1); chk("R6", 28);
    cur_req = "R2"; active_cores = 4'd1; temp_c = 8'd76; ticks(2); chk("R2", 30);
    temp_c = 8'd77; ticks(1); chk("R2", 29);
    temp_c = 8'd50; power_w = 8'd116; ticks(1); chk("R2", 28);
    power_w = 8'd115; current_over = 1'b1; ticks(1); chk("R2", 27);
    cur_req = "R5"; ticks(10); chk("R5", 20);
    base_code = 6'd30; ticks(1); chk("R5", 24);
    current_over = 1'b0; base_code = 6'd5; ticks(1); chk("R3", 25);
    current_over = 1'b1; ticks(20); chk("R5", 12);
    cur_req = "R6"; current_over = 1'b0; ticks(20); chk("R4", 32);
    active_cores = 4'd6; temp_c = 8'd90; ticks(1); chk("R6", 28);
    cur_req = "R7"; temp_c = 8'd50; turbo_en = 1'b0; base_code = 6'd18;
    @(negedge clk); chk("R7", 18);
    repeat (TICK - 1) @(negedge clk);
    turbo_en = 1'b1; active_cores = 4'd0; ticks(2); chk("R7", 18);
    cur_req = "R3"; active_cores = 4'd2; ticks(1); chk("R3", 19);
    ticks(15); chk("R4", 31);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule